// File: doc/BRIEF.md
# Port Command and Self-Test Sequencer

This block is the host-facing command register of a network controller. The host writes one 32-bit word. The low nibble picks an operation: a full software reset, a selective reset, or a self-test. The upper 28 bits carry a 16-byte-aligned pointer to the memory location that receives the self-test result. After the write the block runs the operation with no further help from the host. It drives reset requests to the command and receive units and to the configuration store. It starts the stub test checkers and collects their pass/fail flags. It then writes one result word to memory over a single-beat valid/ready write channel.

A selective reset only idles the command and receive units, so configuration survives it. A full reset also clears the configuration store. A self-test runs four phases in order: a selective reset, the test phase, the result write, and a full reset that restores defaults. The host gets no completion signal. It polls the register, which reads back zero once the operation is over. Each reset phase lasts a fixed, parameterised number of clock cycles to model settling time.

Top module: `portcmd_seq`

## Requirements
- R1: A write whose function nibble (bits 3:0) is not 4'b0000 (full reset), 4'b0001 (self-test) or 4'b0010 (selective reset) is ignored. The register stays zero, `busy` stays low and no request output rises.
- R2: A host write while `busy` is high is ignored. The readback value does not change.
- R3: From the cycle after an accepted write until the operation ends, `host_rd_data` returns the written word. It reads zero in the cycle where `busy` first reads low again.
- R4: A selective reset (4'b0010) holds `unit_idle_req` high for exactly SEL_CYCLES cycles and never raises `cfg_clear_req`. After that the block is idle.
- R5: A full reset (4'b0000) holds both `cfg_clear_req` and `unit_idle_req` high for exactly FULL_CYCLES cycles. After that the block is idle.
- R6: A self-test (4'b0001) runs four phases in this order: `unit_idle_req` alone for SEL_CYCLES cycles, then `tst_run` until `tst_done` is sampled high, then the memory write, then the full-reset phase of R5.
- R7: The result write address is bits 31:4 of the written word, with bits 3:0 forced to zero.
- R8: In the result word, bit 5 is the serial diagnose fail, bit 3 the register-test fail and bit 2 the ROM-test fail. Bit 12 is the OR of those three bits. A value of 1 means fail, and every other bit is zero.
- R9: `mem_wr_valid` stays high with stable address and data until `mem_wr_ready` is sampled high. The full-reset phase starts only in the cycle after that acceptance.
- R10: `busy` is high from the cycle after an accepted write up to and including the last cycle of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for the command register |
| host_wr_data | input | 32 | Pointer in bits 31:4 and function in bits 3:0 |
| host_rd_data | output | 32 | Command register readback |
| busy | output | 1 | An operation is in progress |
| unit_idle_req | output | 1 | Forces the command and receive units to idle |
| cfg_clear_req | output | 1 | Clears the configuration store to defaults |
| tst_run | output | 1 | Test checkers are running |
| tst_done | input | 1 | Test checkers have finished; fail flags are valid |
| tst_serial_fail | input | 1 | Serial diagnose failed |
| tst_reg_fail | input | 1 | Register test failed |
| tst_rom_fail | input | 1 | ROM test failed |
| mem_wr_valid | output | 1 | Result write request |
| mem_wr_ready | input | 1 | Memory accepts the write |
| mem_wr_addr | output | 32 | Result write byte address |
| mem_wr_data | output | 32 | Result word |

## Verification
A sequencer stuck in the wrong phase shows up within one cycle. The request outputs would carry the wrong mix: `cfg_clear_req` during a selective reset, or `tst_run` without a preceding idle phase. A miscounted phase shows up as a pulse one cycle too long or too short, which is visible as soon as the phase ends. A wrongly captured fail flag or pointer appears on the write channel as soon as `mem_wr_valid` rises. A register that fails to clear, or that accepts a write while busy, shows on the readback port in the next cycle.

// File: rtl/portcmd_pkg.sv
package portcmd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SEL   = 3'd1,
    ST_TEST  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FULL  = 3'd4
  } seq_state_t;

  localparam int FUNC_W = 4;
  localparam logic [FUNC_W-1:0] FN_FULL = 4'h0;
  localparam logic [FUNC_W-1:0] FN_TEST = 4'h1;
  localparam logic [FUNC_W-1:0] FN_SEL  = 4'h2;

  localparam int BIT_GENERAL = 12;
  localparam int BIT_SERIAL  = 5;
  localparam int BIT_REGTEST = 3;
  localparam int BIT_ROMTEST = 2;

  function automatic logic func_valid(input logic [FUNC_W-1:0] f);
    return (f == FN_FULL) || (f == FN_TEST) || (f == FN_SEL);
  endfunction

endpackage

// File: rtl/portcmd_reg.sv
module portcmd_reg
  import portcmd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              clear,
  output logic              accept,
  output logic [DATA_W-1:0] cmd_q
);

  // A write lands only when idle and carrying a defined function code.
  assign accept = wr_en && !busy && func_valid(wr_data[FUNC_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (accept) begin
      cmd_q <= wr_data;
    end else if (clear) begin
      cmd_q <= '0;
    end
  end

endmodule

// File: rtl/portcmd_fsm.sv
module portcmd_fsm
  import portcmd_pkg::*;
#(
  parameter int SEL_CYCLES  = 4,
  parameter int FULL_CYCLES = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [FUNC_W-1:0] func,
  input  logic              tst_done,
  input  logic              wr_accept,
  output seq_state_t        state,
  output logic              done,
  output logic              capture
);

  localparam int MAX_CYC = (SEL_CYCLES > FULL_CYCLES) ? SEL_CYCLES : FULL_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SEL_LAST  = CNT_W'(SEL_CYCLES - 1);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(FULL_CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             is_test;
  logic             sel_last, full_last;

  assign sel_last  = (state == ST_SEL)  && (cnt == SEL_LAST);
  assign full_last = (state == ST_FULL) && (cnt == FULL_LAST);
  assign done      = (sel_last && !is_test) || full_last;
  assign capture   = (state == ST_TEST) && tst_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      is_test <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept) begin
            is_test <= (func == FN_TEST);
            state   <= (func == FN_FULL) ? ST_FULL : ST_SEL;
          end
        end
        ST_SEL: begin
          if (sel_last) begin
            cnt   <= '0;
            state <= is_test ? ST_TEST : ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TEST: begin
          if (tst_done) state <= ST_WRITE;
        end
        ST_WRITE: begin
          cnt <= '0;
          if (wr_accept) state <= ST_FULL;
        end
        ST_FULL: begin
          if (full_last) begin
            cnt     <= '0;
            is_test <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/portcmd_result.sv
module portcmd_result
  import portcmd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ALIGN  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              serial_fail,
  input  logic              reg_fail,
  input  logic              rom_fail,
  input  logic [DATA_W-1:0] cmd_q,
  output logic [DATA_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);

  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] word_d;

  always_comb begin
    word_d = '0;
    word_d[BIT_SERIAL]  = serial_fail;
    word_d[BIT_REGTEST] = reg_fail;
    word_d[BIT_ROMTEST] = rom_fail;
    word_d[BIT_GENERAL] = serial_fail | reg_fail | rom_fail;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (capture) begin
      word_q <= word_d;
    end
  end

  assign wr_data = word_q;
  assign wr_addr = {cmd_q[DATA_W-1:ALIGN], {ALIGN{1'b0}}};

endmodule

// File: rtl/portcmd_seq.sv
module portcmd_seq
  import portcmd_pkg::*;
#(
  parameter int SEL_CYCLES  = 4,
  parameter int FULL_CYCLES = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr_en,
  input  logic [31:0] host_wr_data,
  output logic [31:0] host_rd_data,
  output logic        busy,
  output logic        unit_idle_req,
  output logic        cfg_clear_req,
  output logic        tst_run,
  input  logic        tst_done,
  input  logic        tst_serial_fail,
  input  logic        tst_reg_fail,
  input  logic        tst_rom_fail,
  output logic        mem_wr_valid,
  input  logic        mem_wr_ready,
  output logic [31:0] mem_wr_addr,
  output logic [31:0] mem_wr_data
);

  localparam int DATA_W = 32;
  localparam int ALIGN  = 4;

  seq_state_t        state;
  logic              accept, done, capture;
  logic [DATA_W-1:0] cmd_q;

  assign busy = (state != ST_IDLE);

  portcmd_reg #(.DATA_W(DATA_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (host_wr_en),
    .wr_data (host_wr_data),
    .busy    (busy),
    .clear   (done),
    .accept  (accept),
    .cmd_q   (cmd_q)
  );

  portcmd_fsm #(.SEL_CYCLES(SEL_CYCLES), .FULL_CYCLES(FULL_CYCLES)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .func      (host_wr_data[FUNC_W-1:0]),
    .tst_done  (tst_done),
    .wr_accept (mem_wr_valid && mem_wr_ready),
    .state     (state),
    .done      (done),
    .capture   (capture)
  );

  portcmd_result #(.DATA_W(DATA_W), .ALIGN(ALIGN)) u_res (
    .clk         (clk),
    .rst         (rst),
    .capture     (capture),
    .serial_fail (tst_serial_fail),
    .reg_fail    (tst_reg_fail),
    .rom_fail    (tst_rom_fail),
    .cmd_q       (cmd_q),
    .wr_addr     (mem_wr_addr),
    .wr_data     (mem_wr_data)
  );

  assign host_rd_data  = cmd_q;
  assign unit_idle_req = (state == ST_SEL) || (state == ST_FULL);
  assign cfg_clear_req = (state == ST_FULL);
  assign tst_run       = (state == ST_TEST);
  assign mem_wr_valid  = (state == ST_WRITE);

endmodule

// File: rtl/portcmd_seq_sva.sv
module portcmd_seq_sva (
  input logic        clk,
  input logic        rst,
  input logic        host_wr_en,
  input logic [31:0] host_rd_data,
  input logic        busy,
  input logic        unit_idle_req,
  input logic        cfg_clear_req,
  input logic        tst_run,
  input logic        tst_done,
  input logic        mem_wr_valid,
  input logic        mem_wr_ready,
  input logic [31:0] mem_wr_addr,
  input logic [31:0] mem_wr_data
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(unit_idle_req || cfg_clear_req || tst_run || mem_wr_valid));

  p_busy_write_ignored_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && host_wr_en) |=> (!busy || $stable(host_rd_data)));

  p_clear_on_done_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (host_rd_data == 32'h0));

  p_clear_implies_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cfg_clear_req |-> unit_idle_req);

  p_test_then_write_r6: assert property (@(posedge clk) disable iff (rst)
    (tst_run && tst_done) |=> mem_wr_valid);

  p_addr_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_addr[3:0] == 4'h0));

  p_result_format_r8: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> ((mem_wr_data & ~32'h0000_102C) == 32'h0) &&
                     (mem_wr_data[12] == (mem_wr_data[5] | mem_wr_data[3] | mem_wr_data[2])));

  p_write_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  p_write_to_full_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && mem_wr_ready) |=> (cfg_clear_req && !mem_wr_valid));

endmodule

bind portcmd_seq portcmd_seq_sva i_portcmd_seq_sva (
  .clk           (clk),
  .rst           (rst),
  .host_wr_en    (host_wr_en),
  .host_rd_data  (host_rd_data),
  .busy          (busy),
  .unit_idle_req (unit_idle_req),
  .cfg_clear_req (cfg_clear_req),
  .tst_run       (tst_run),
  .tst_done      (tst_done),
  .mem_wr_valid  (mem_wr_valid),
  .mem_wr_ready  (mem_wr_ready),
  .mem_wr_addr   (mem_wr_addr),
  .mem_wr_data   (mem_wr_data)
);

// File: tb/test_portcmd_seq.sv
module test_portcmd_seq;

  localparam int CLK_PERIOD  = 10;
  localparam int SEL_CYCLES  = 4;
  localparam int FULL_CYCLES = 6;
  localparam int WATCHDOG    = 20000;
  localparam int NVEC        = 5;

  // Self-test vectors: command word, fail flags {serial,reg,rom}, expected address and result word.
  localparam logic [31:0] V_CMD  [NVEC] = '{32'h0000_1231, 32'hABCD_EF01, 32'h8000_0011,
                                            32'h0FFF_FFF1, 32'h1234_5671};
  localparam logic [2:0]  V_FAIL [NVEC] = '{3'b000, 3'b100, 3'b010, 3'b001, 3'b111};
  localparam logic [31:0] V_ADDR [NVEC] = '{32'h0000_1230, 32'hABCD_EF00, 32'h8000_0010,
                                            32'h0FFF_FFF0, 32'h1234_5670};
  localparam logic [31:0] V_DATA [NVEC] = '{32'h0000_0000, 32'h0000_1020, 32'h0000_1008,
                                            32'h0000_1004, 32'h0000_102C};
  localparam int          V_RDLY [NVEC] = '{0, 2, 1, 3, 0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic [31:0] host_rd_data;
  logic        busy, unit_idle_req, cfg_clear_req, tst_run;
  logic        tst_done = 1'b0;
  logic        tst_serial_fail = 1'b0, tst_reg_fail = 1'b0, tst_rom_fail = 1'b0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [31:0] mem_wr_addr, mem_wr_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  portcmd_seq #(.SEL_CYCLES(SEL_CYCLES), .FULL_CYCLES(FULL_CYCLES)) i_portcmd_seq (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .host_rd_data(host_rd_data), .busy(busy), .unit_idle_req(unit_idle_req),
    .cfg_clear_req(cfg_clear_req), .tst_run(tst_run), .tst_done(tst_done),
    .tst_serial_fail(tst_serial_fail), .tst_reg_fail(tst_reg_fail),
    .tst_rom_fail(tst_rom_fail), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  // Drive one write strobe between two falling edges; returns at the falling edge after it.
  task automatic host_write(input logic [31:0] d);
    @(negedge clk);
    host_wr_en   = 1'b1;
    host_wr_data = d;
    @(negedge clk);
    host_wr_en   = 1'b0;
  endtask

  // Count the cycles a request stays high, starting at the current falling edge.
  task automatic count_high(input bit which_cfg, output int n, output int cfg_seen);
    n = 0;
    cfg_seen = 0;
    while ((which_cfg ? cfg_clear_req : (unit_idle_req && !cfg_clear_req)) && n < 100) begin
      n++;
      if (cfg_clear_req) cfg_seen++;
      @(negedge clk);
    end
  endtask

  task automatic run_selftest(input int k);
    int n, cs;
    host_write(V_CMD[k]);
    chk("R3 readback during self-test", host_rd_data, V_CMD[k]);
    chk("R10 busy after write", {31'b0, busy}, 32'd1);
    count_high(1'b0, n, cs);
    chk("R6 selective phase length", n, SEL_CYCLES);
    chk("R6 test phase follows", {31'b0, tst_run}, 32'd1);
    {tst_serial_fail, tst_reg_fail, tst_rom_fail} = V_FAIL[k];
    @(negedge clk);
    chk("R6 still testing without done", {31'b0, tst_run}, 32'd1);
    tst_done = 1'b1;
    @(negedge clk);
    tst_done = 1'b0;
    {tst_serial_fail, tst_reg_fail, tst_rom_fail} = 3'b000;
    chk("R6 write after test", {31'b0, mem_wr_valid}, 32'd1);
    chk("R7 write address", mem_wr_addr, V_ADDR[k]);
    chk("R8 result word", mem_wr_data, V_DATA[k]);
    for (int d = 0; d < V_RDLY[k]; d++) begin
      @(negedge clk);
      chk("R9 valid held", {31'b0, mem_wr_valid}, 32'd1);
      chk("R9 data held", mem_wr_data, V_DATA[k]);
      chk("R9 no full reset before accept", {31'b0, cfg_clear_req}, 32'd0);
    end
    mem_wr_ready = 1'b1;
    @(negedge clk);
    mem_wr_ready = 1'b0;
    chk("R9 valid drops after accept", {31'b0, mem_wr_valid}, 32'd0);
    count_high(1'b1, n, cs);
    chk("R5 final full reset length", n, FULL_CYCLES);
    chk("R3 cleared after self-test", host_rd_data, 32'h0);
    chk("R10 idle after self-test", {31'b0, busy}, 32'd0);
  endtask

  initial begin
    int n, cs;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 reset readback", host_rd_data, 32'h0);
    chk("R10 reset busy", {31'b0, busy}, 32'd0);
    chk("R1 reset requests", {28'b0, unit_idle_req, cfg_clear_req, tst_run, mem_wr_valid}, 32'd0);

    for (int k = 0; k < NVEC; k++) run_selftest(k);

    // R4: selective reset alone.
    host_write(32'h0000_0052);
    chk("R3 readback selective", host_rd_data, 32'h0000_0052);
    count_high(1'b0, n, cs);
    chk("R4 selective length", n, SEL_CYCLES);
    chk("R4 no config clear", cs, 0);
    chk("R4 idle after selective", {30'b0, busy, tst_run}, 32'd0);
    chk("R3 cleared after selective", host_rd_data, 32'h0);

    // R5: full reset, nonzero pointer bits.
    host_write(32'h0000_0A40);
    chk("R3 readback full", host_rd_data, 32'h0000_0A40);
    count_high(1'b1, n, cs);
    chk("R5 full length", n, FULL_CYCLES);
    chk("R5 idle after full", {31'b0, busy}, 32'd0);
    chk("R5 unit idle dropped", {31'b0, unit_idle_req}, 32'd0);

    // R1: reserved codes.
    host_write(32'h0000_1233);
    chk("R1 reserved 3 readback", host_rd_data, 32'h0);
    chk("R1 reserved 3 busy", {31'b0, busy}, 32'd0);
    host_write(32'hFFFF_FFFF);
    chk("R1 reserved F readback", host_rd_data, 32'h0);
    chk("R1 reserved F requests", {29'b0, unit_idle_req, cfg_clear_req, busy}, 32'd0);

    // R2: write during a selective reset is dropped.
    host_write(32'h0000_0072);
    host_wr_en = 1'b1;
    host_wr_data = 32'h0000_0001;
    @(negedge clk);
    host_wr_en = 1'b0;
    chk("R2 readback unchanged", host_rd_data, 32'h0000_0072);
    count_high(1'b0, n, cs);
    chk("R2 selective length unchanged", n, SEL_CYCLES - 1);
    chk("R2 no test started", {31'b0, tst_run}, 32'd0);
    chk("R2 cleared", host_rd_data, 32'h0);

    // Reset in the middle of an operation.
    host_write(32'h0000_0001);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R3 reset mid-operation readback", host_rd_data, 32'h0);
    chk("R10 reset mid-operation busy", {31'b0, busy}, 32'd0);

    finish_run();
  end

endmodule